// File: doc/BRIEF.md
# Dual-Mode Block Copy Engine

This block is a single-channel copy engine that moves a programmed number of bytes from one memory region to another. It shares the memory bus with a processor and gets at it through a request and grant handshake with an external arbiter. Software writes a source address, a destination address and a byte count. A write to the control register then starts the copy and picks one of two bus policies for it.

In hold mode the engine keeps the bus from the first grant until the last byte has been written. In steal mode it takes the bus for exactly one byte, drops its request for at least one cycle so the arbiter can serve the processor, and then asks again. Each byte is a one-cycle read from the source followed by a one-cycle write to the destination, and both addresses then step up by one. The processor gets no per-byte interrupt. A single sticky interrupt flag rises once the whole block has been copied, and software clears it by writing the control register.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, busy, irq, bus_req, bus_rd and bus_wr are all low.
- R2: Each byte is copied in two consecutive bus cycles. The first is a read cycle (bus_rd high, bus_addr is the source pointer) and the second a write cycle (bus_wr high, bus_addr is the destination pointer, bus_wdata equals the bus_rdata sampled during the read). bus_rd and bus_wr are never high together.
- R3: After every byte both pointers advance by one. A run moves exactly the programmed count of bytes, and memory outside the destination window is untouched.
- R4: Once started, the engine raises bus_req and does not issue a read or write until bus_gnt is high. Every access cycle has both bus_req and bus_gnt high.
- R5: In hold mode (control bit 1 = 0), the read of the next byte follows the write of the previous byte directly, with bus_req kept high. bus_req falls in the cycle after the final write.
- R6: In steal mode (control bit 1 = 1), bus_req is low in the cycle after every write, and the engine requests again in the cycle after that if bytes remain.
- R7: irq becomes 1 in the cycle after the final write and stays 1 until a control write with bit 2 set clears it. A completion in the same cycle as a clear leaves irq set.
- R8: A start with a programmed count of zero sets irq in the next cycle. It raises no bus_req and does not make busy high.
- R9: A start command issued while busy is high is ignored. The running copy continues with its original pointers and count.
- R10: Register select: 0 = source address, 1 = destination address, 2 = 16-bit byte count, 3 = control (bit 0 start, bit 1 steal mode, bit 2 clear irq). Writing select 0 to 2 during a run does not affect the run.
- R11: busy is high from the cycle after an accepted non-zero start until the cycle after the final write. bus_req is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rd | output | 1 | Read strobe for the current cycle |
| bus_wr | output | 1 | Write strobe for the current cycle |
| bus_addr | output | 16 | Byte address of the current access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| busy | output | 1 | A copy is in progress |
| irq | output | 1 | Sticky completion interrupt |

## Verification
A four-byte hold-mode copy with an immediate grant is compared against a three-byte steal-mode copy whose first grant is held back by the processor. The first shows back-to-back reads and writes under one tenure. The second shows the dropped request after each write and the wait on a late grant. A one-byte copy puts the first byte and the last byte in the same beat, and a zero-count start is meant to finish without touching the bus. A start and pointer writes arriving in the middle of a run check that a busy engine ignores new commands. A clear written while irq is set checks the sticky flag.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 8;
  localparam int CFG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;

  localparam int CTRL_START = 0;
  localparam int CTRL_STEAL = 1;
  localparam int CTRL_CLEAR = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_WAIT,
    XS_READ,
    XS_WRITE,
    XS_GAP
  } xfer_state_e;

  function automatic addr_t addr_advance(addr_t a);
    return a + addr_t'(1);
  endfunction

  function automatic cnt_t cnt_retire(cnt_t c);
    return c - cnt_t'(1);
  endfunction

  function automatic logic cnt_is_last(cnt_t c);
    return c == cnt_t'(1);
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output addr_t            prog_src,
  output addr_t            prog_dst,
  output cnt_t             prog_cnt,
  output logic             start_cmd,
  output logic             mode_cmd,
  output logic             clr_cmd
);
  logic ctrl_hit;

  always_comb begin
    ctrl_hit  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
    start_cmd = ctrl_hit && cfg_wdata[CTRL_START];
    mode_cmd  = cfg_wdata[CTRL_STEAL];
    clr_cmd   = ctrl_hit && cfg_wdata[CTRL_CLEAR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_src <= '0;
      prog_dst <= '0;
      prog_cnt <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_SRC: prog_src <= cfg_wdata[ADDR_W-1:0];
        SEL_DST: prog_dst <= cfg_wdata[ADDR_W-1:0];
        SEL_CNT: prog_cnt <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr_evt) irq <= 1'b0;
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_cmd,
  input  logic  mode_cmd,
  input  addr_t prog_src,
  input  addr_t prog_dst,
  input  cnt_t  prog_cnt,
  input  logic  bus_gnt,
  input  data_t bus_rdata,
  output logic  bus_req,
  output logic  bus_rd,
  output logic  bus_wr,
  output addr_t bus_addr,
  output data_t bus_wdata,
  output logic  busy,
  output logic  start_evt,
  output logic  zero_start,
  output logic  done_evt,
  output logic  steal_mode
);
  xfer_state_e state_q, state_d;
  addr_t src_q, dst_q;
  cnt_t  cnt_q;
  data_t data_q;
  logic  mode_q;
  logic  last_beat;

  always_comb begin
    busy       = (state_q != XS_IDLE);
    bus_rd     = (state_q == XS_READ);
    bus_wr     = (state_q == XS_WRITE);
    bus_req    = (state_q == XS_WAIT) || bus_rd || bus_wr;
    bus_addr   = bus_rd ? src_q : (bus_wr ? dst_q : '0);
    bus_wdata  = data_q;
    start_evt  = start_cmd && !busy;
    zero_start = start_evt && (prog_cnt == '0);
    last_beat  = bus_wr && cnt_is_last(cnt_q);
    done_evt   = last_beat || zero_start;
    steal_mode = mode_q;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:  if (start_evt && !zero_start) state_d = XS_WAIT;
      XS_WAIT:  if (bus_gnt) state_d = XS_READ;
      XS_READ:  state_d = XS_WRITE;
      XS_WRITE: begin
        if (last_beat)   state_d = XS_IDLE;
        else if (mode_q) state_d = XS_GAP;
        else             state_d = XS_READ;
      end
      XS_GAP:   state_d = XS_WAIT;
      default:  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_evt && !zero_start) begin
        src_q  <= prog_src;
        dst_q  <= prog_dst;
        cnt_q  <= prog_cnt;
        mode_q <= mode_cmd;
      end
      if (bus_rd) data_q <= bus_rdata;
      if (bus_wr) begin
        src_q <= addr_advance(src_q);
        dst_q <= addr_advance(dst_q);
        cnt_q <= cnt_retire(cnt_q);
      end
    end
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        busy,
  output logic        irq
);
  import dma_xfer_pkg::*;

  addr_t prog_src, prog_dst;
  cnt_t  prog_cnt;
  logic  start_cmd, mode_cmd, clr_evt;
  logic  start_evt, zero_start, done_evt, steal_mode;

  dma_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .prog_src  (prog_src),
    .prog_dst  (prog_dst),
    .prog_cnt  (prog_cnt),
    .start_cmd (start_cmd),
    .mode_cmd  (mode_cmd),
    .clr_cmd   (clr_evt)
  );

  dma_xfer_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_cmd  (start_cmd),
    .mode_cmd   (mode_cmd),
    .prog_src   (prog_src),
    .prog_dst   (prog_dst),
    .prog_cnt   (prog_cnt),
    .bus_gnt    (bus_gnt),
    .bus_rdata  (bus_rdata),
    .bus_req    (bus_req),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .start_evt  (start_evt),
    .zero_start (zero_start),
    .done_evt   (done_evt),
    .steal_mode (steal_mode)
  );

  dma_irq_flag u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (done_evt),
    .clr_evt (clr_evt),
    .irq     (irq)
  );
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic [7:0] bus_wdata,
  input logic       busy,
  input logic       irq,
  input logic       start_evt,
  input logic       zero_start,
  input logic       done_evt,
  input logic       steal_mode,
  input logic       clr_evt
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!bus_req && !bus_rd && !bus_wr)); // R11
  AST_ACCESS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd || bus_wr) |-> (bus_req && bus_gnt)); // R4
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R2
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> bus_wr); // R2
  AST_DATA_COPIED: assert property (@(posedge clk) disable iff (!rst_n) bus_wr |-> (bus_wdata == $past(bus_rdata))); // R2
  AST_HOLD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && !steal_mode && !done_evt) |=> (bus_rd && bus_req)); // R5
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && done_evt) |=> !bus_req); // R5
  AST_STEAL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && steal_mode) |=> !bus_req); // R6
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) done_evt |=> irq); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq && !clr_evt) |=> irq); // R7
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) zero_start |=> (!bus_req && !busy)); // R8
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start_evt |-> !busy); // R9
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .irq        (irq),
  .start_evt  (start_evt),
  .zero_start (zero_start),
  .done_evt   (done_evt),
  .steal_mode (steal_mode),
  .clr_evt    (clr_evt)
);

// File: tb/dma_xfer_ctrl_test.sv
`timescale 1ns/100ps
module dma_xfer_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        bus_req, bus_rd, bus_wr, busy, irq;
  logic        bus_gnt;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  logic [7:0] mem [256];
  logic gnt_q = 1'b0;
  logic cpu_lets_go = 1'b1;
  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  dma_xfer_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .irq(irq)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  // Bench-side arbiter and memory: grant follows request by one cycle, never preempts.
  assign bus_gnt   = gnt_q;
  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= bus_req && (gnt_q || cpu_lets_go);
    if (rst_n && bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
  end

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: remaining bytes, pointers and phase kept as plain integers.
  int m_phase = 0;      // 0 none, 1 asking, 2 reading, 3 writing, 4 yielding
  int m_left = 0, p_cnt = 0;
  int m_src = 0, m_dst = 0, p_src = 0, p_dst = 0;
  bit m_steal = 0, m_irq = 0;
  int m_byte = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; p_cnt = 0; m_src = 0; m_dst = 0;
      p_src = 0; p_dst = 0; m_steal = 0; m_irq = 0; m_byte = 0;
    end else begin
      int was;
      was = m_phase;
      if (cfg_we && cfg_sel == 2'd3 && cfg_wdata[2]) m_irq = 0;
      case (was)
        1: if (bus_gnt) m_phase = 2;
        2: begin m_byte = mem[m_src % 256]; m_phase = 3; end
        3: begin
          m_src = (m_src + 1) % 65536; m_dst = (m_dst + 1) % 65536; m_left--;
          if (m_left == 0) begin m_phase = 0; m_irq = 1; end
          else m_phase = m_steal ? 4 : 2;
        end
        4: m_phase = 1;
        default: ;
      endcase
      if (cfg_we) begin
        if (cfg_sel == 2'd3 && cfg_wdata[0] && was == 0) begin
          if (p_cnt == 0) m_irq = 1;
          else begin
            m_src = p_src; m_dst = p_dst; m_left = p_cnt;
            m_steal = cfg_wdata[1]; m_phase = 1;
          end
        end
        if (cfg_sel == 2'd0) p_src = cfg_wdata;
        if (cfg_sel == 2'd1) p_dst = cfg_wdata;
        if (cfg_sel == 2'd2) p_cnt = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R4/R5/R6", bus_req, (m_phase >= 1 && m_phase <= 3), "bus_req");
      chk("R2", bus_rd, (m_phase == 2), "bus_rd");
      chk("R2", bus_wr, (m_phase == 3), "bus_wr");
      chk("R11", busy, (m_phase != 0), "busy");
      chk("R7/R8", irq, m_irq, "irq");
      if (m_phase == 2) chk("R3/R10", bus_addr, m_src, "read address");
      if (m_phase == 3) begin
        chk("R3/R10", bus_addr, m_dst, "write address");
        chk("R2", bus_wdata, m_byte, "write data");
      end
    end
  end

  task automatic cfg_write(logic [1:0] sel, logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic check_copy(string tag, int src, int dst, int n);
    for (int i = 0; i < n; i++) chk(tag, mem[dst + i], pat(src + i), "copied byte");
    chk(tag, mem[dst + n], pat(dst + n), "byte past window");
    chk(tag, mem[dst - 1], pat(dst - 1), "byte before window");
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R11 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    chk("R1", busy, 0, "busy in reset");
    chk("R1", bus_req, 0, "bus_req in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", irq, 0, "irq after reset");
    chk("R1", bus_rd | bus_wr, 0, "strobes after reset");
    live = 1'b1;

    // Hold mode, four bytes, immediate grant
    cfg_write(2'd0, 16'h0010);
    cfg_write(2'd1, 16'h0080);
    cfg_write(2'd2, 16'd4);
    cfg_write(2'd3, 16'h0001);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R7", irq, 1, "irq held after hold-mode run");
    check_copy("R3", 16'h10, 16'h80, 4);

    // Clear the sticky flag
    cfg_write(2'd3, 16'h0004);
    chk("R7", irq, 0, "irq after clear");

    // Steal mode, three bytes, processor delays the first grant
    cpu_lets_go = 1'b0;
    cfg_write(2'd0, 16'h0020);
    cfg_write(2'd1, 16'h00A0);
    cfg_write(2'd2, 16'd3);
    cfg_write(2'd3, 16'h0003);
    repeat (4) @(negedge clk);
    chk("R4", bus_req, 1, "request pending without grant");
    cpu_lets_go = 1'b1;
    // A start and new pointers during the run must not disturb it
    cfg_write(2'd0, 16'h0040);
    cfg_write(2'd3, 16'h0001);
    wait_idle();
    @(negedge clk);
    check_copy("R9", 16'h20, 16'hA0, 3);
    chk("R6", irq, 1, "irq after steal run");
    cfg_write(2'd3, 16'h0004);

    // Zero count
    cfg_write(2'd2, 16'd0);
    cfg_write(2'd3, 16'h0001);
    chk("R8", irq, 1, "irq after zero-count start");
    chk("R8", busy, 0, "busy after zero-count start");
    cfg_write(2'd3, 16'h0004);

    // Single byte hold mode
    cfg_write(2'd0, 16'h0030);
    cfg_write(2'd1, 16'h00C0);
    cfg_write(2'd2, 16'd1);
    cfg_write(2'd3, 16'h0000);
    chk("R10", busy, 0, "control write without start bit");
    cfg_write(2'd3, 16'h0001);
    wait_idle();
    @(negedge clk);
    check_copy("R5", 16'h30, 16'hC0, 1);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule